// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block takes one 16-bit instruction word and works out where each of its two operands lives. The opcode sits in bits 4:0, the destination field (b) in bits 9:5 and the source field (a) in bits 15:10. For each operand the decoder reports a register selection, a memory address or an immediate value. It also returns the updated program counter and stack pointer, and how many extra cycles the addressing modes cost. Executing the instruction is left to the surrounding core.

A pulse on `start` loads the instruction and the current PC and SP. The source operand is resolved first and the destination operand second. When a mode needs the word that follows the instruction, the decoder asks for it on a valid/ready fetch port at the running PC. When a mode needs a general register value, it reads it through a combinational read port. After both operands are resolved, `done` pulses for one cycle and the results stay on the outputs until the next start.

Top module: `operand_resolver`

## Requirements
- R1: Modes 0x00-0x07 give kind REG (0) with select equal to the mode. Modes 0x1b, 0x1c and 0x1d give kind REG with select 8 (SP), 9 (PC) and 10 (EX). A REG result reports a value of 0. Every non-REG result reports a select of 0.
- R2: Modes 0x08-0x0f read general register (mode-8) and give kind MEM (1), with the address equal to that register's value.
- R3: Modes 0x10-0x17 fetch the word at the running PC, advance PC by 1, add 1 extra cycle, and give kind MEM at the address word plus register (mode-0x10).
- R4: Mode 0x18 in the a field pops: kind MEM at address SP, then SP+1. In the b field it pushes: SP-1 first, then kind MEM at the new SP.
- R5: Mode 0x19 gives kind MEM at SP and leaves SP unchanged. Mode 0x1a fetches a word, advances PC, adds 1 cycle, and gives kind MEM at SP plus the word.
- R6: Mode 0x1e fetches a word and gives kind MEM at that word. Mode 0x1f fetches a word and gives kind LIT (2) with that word as the value. Each advances PC and adds 1 cycle.
- R7: a-field values 0x20-0x3f give kind LIT with the value (field - 0x21) modulo 2^16. So 0x20 gives 0xFFFF, 0x21 gives 0 and 0x3f gives 30.
- R8: The a operand is resolved before the b operand. The a operand's next word comes from the starting PC and the b operand's from the PC after it. Any SP change made by the a operand is seen by the b operand.
- R9: When the opcode is 0, the b operand gives kind EXT (3) with the raw 5-bit field as its value. It makes no fetch and changes neither PC, SP nor the cycle count.
- R10: A fetch request keeps `fetchValid` high and `fetchAddr` stable until `fetchReady`. `done` is a one-cycle pulse that rises 3 cycles after the start edge, plus one cycle for every cycle that `fetchReady` was held low.
- R11: A `start` that arrives while `busy` is high is ignored and does not change the results of the instruction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load an instruction and begin decoding |
| instr | input | 16 | Instruction word |
| pcIn | input | 16 | PC value, already pointing past the instruction word |
| spIn | input | 16 | Stack pointer at start |
| regRdIdx | output | 3 | General register read index |
| regRdData | input | 16 | Value of the indexed register (combinational) |
| fetchValid | output | 1 | Next-word fetch request |
| fetchAddr | output | 16 | Fetch address (running PC) |
| fetchReady | input | 1 | Fetch accepted, data valid |
| fetchData | input | 16 | Fetched word |
| aKind | output | 2 | a operand kind: 0 REG, 1 MEM, 2 LIT, 3 EXT |
| aSel | output | 4 | a register select |
| aVal | output | 16 | a address or literal |
| bKind | output | 2 | b operand kind |
| bSel | output | 4 | b register select |
| bVal | output | 16 | b address, literal or extended opcode |
| pcOut | output | 16 | PC after the operand words |
| spOut | output | 16 | SP after stack modes |
| extraCyc | output | 2 | Extra cycles spent on next-word modes |
| busy | output | 1 | Decode in progress |
| done | output | 1 | Results valid (one-cycle pulse) |

## Verification
Each operand takes one cycle when `fetchReady` is already high. So `done` is due on the third cycle after the start edge, and each cycle of withheld ready delays it by one. The bench holds ready low for a chosen number of cycles on every fetch and predicts the exact cycle `done` should appear. It samples on the falling edge, counts cycles from start, and compares every result against the prediction on that cycle. It also checks each fetch address on every cycle while a request is pending.

// File: rtl/operand_resolver_pkg.sv
package operand_resolver_pkg;
  typedef enum logic [1:0] {
    KIND_REG = 2'd0,
    KIND_MEM = 2'd1,
    KIND_LIT = 2'd2,
    KIND_EXT = 2'd3
  } opKind_t;

  typedef struct packed {
    logic load;    // capture instruction, PC, SP
    logic selB;    // resolving the b operand
    logic commit;  // current operand resolves this cycle
  } ctrlStrobe_t;

  localparam int SEL_SP = 8;
  localparam int SEL_PC = 9;
  localparam int SEL_EX = 10;
endpackage

// File: rtl/opd_ctrl.sv
module opd_ctrl
  import operand_resolver_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        needWord,
  input  logic        fetchReady,
  output ctrlStrobe_t strobe,
  output logic        fetchValid,
  output logic        busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_OPA, ST_OPB} state_t;
  state_t state;

  always_comb begin
    busy          = (state != ST_IDLE);
    fetchValid    = busy && needWord;
    strobe.load   = (state == ST_IDLE) && start;
    strobe.selB   = (state == ST_OPB);
    strobe.commit = busy && (!needWord || fetchReady);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_OPA;
        ST_OPA:  if (strobe.commit) state <= ST_OPB;
        ST_OPB:  if (strobe.commit) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opd_path.sv
module opd_path
  import operand_resolver_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OPC_W  = 5,
  parameter int FLD_W  = 6,
  parameter int CYC_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] spIn,
  output logic [2:0]        regRdIdx,
  input  logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] fetchData,
  output logic [DATA_W-1:0] fetchAddr,
  output logic              needWord,
  output logic [1:0]        aKind,
  output logic [3:0]        aSel,
  output logic [DATA_W-1:0] aVal,
  output logic [1:0]        bKind,
  output logic [3:0]        bSel,
  output logic [DATA_W-1:0] bVal,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [CYC_W-1:0]  extraCyc,
  output logic              done
);
  localparam int B_LO = OPC_W;
  localparam int B_W  = FLD_W - 1;
  localparam int A_LO = OPC_W + B_W;
  localparam logic [DATA_W-1:0] LIT_BIAS = DATA_W'(33);

  logic [DATA_W-1:0] instrR, pcR, spR;
  logic [FLD_W-1:0]  field;
  logic              isExt;
  opKind_t           kind;
  logic [3:0]        sel;
  logic [DATA_W-1:0] val, pcNext, spNext;

  assign field     = strobe.selB ? {1'b0, instrR[B_LO +: B_W]} : instrR[A_LO +: FLD_W];
  assign isExt     = strobe.selB && (instrR[OPC_W-1:0] == '0);
  assign regRdIdx  = field[2:0];
  assign fetchAddr = pcR;
  assign pcOut     = pcR;
  assign spOut     = spR;

  always_comb begin
    kind     = KIND_REG;
    sel      = '0;
    val      = '0;
    needWord = 1'b0;
    pcNext   = pcR;
    spNext   = spR;
    if (isExt) begin
      kind = KIND_EXT;
      val  = DATA_W'(field);
    end else if (field[FLD_W-1]) begin
      kind = KIND_LIT;
      val  = DATA_W'(field) - LIT_BIAS;
    end else begin
      case (field[4:3])
        2'd0: sel = {1'b0, field[2:0]};
        2'd1: begin kind = KIND_MEM; val = regRdData; end
        2'd2: begin
          kind = KIND_MEM; needWord = 1'b1;
          val = fetchData + regRdData; pcNext = pcR + 1'b1;
        end
        default: begin
          case (field[2:0])
            3'd0: begin
              kind = KIND_MEM;
              if (strobe.selB) begin spNext = spR - 1'b1; val = spR - 1'b1; end
              else begin val = spR; spNext = spR + 1'b1; end
            end
            3'd1: begin kind = KIND_MEM; val = spR; end
            3'd2: begin
              kind = KIND_MEM; needWord = 1'b1;
              val = spR + fetchData; pcNext = pcR + 1'b1;
            end
            3'd3: sel = 4'(SEL_SP);
            3'd4: sel = 4'(SEL_PC);
            3'd5: sel = 4'(SEL_EX);
            3'd6: begin kind = KIND_MEM; needWord = 1'b1; val = fetchData; pcNext = pcR + 1'b1; end
            default: begin kind = KIND_LIT; needWord = 1'b1; val = fetchData; pcNext = pcR + 1'b1; end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrR <= '0; pcR <= '0; spR <= '0; extraCyc <= '0; done <= 1'b0;
      aKind <= '0; aSel <= '0; aVal <= '0;
      bKind <= '0; bSel <= '0; bVal <= '0;
    end else begin
      done <= strobe.commit && strobe.selB;
      if (strobe.load) begin
        instrR <= instr; pcR <= pcIn; spR <= spIn; extraCyc <= '0;
      end else if (strobe.commit) begin
        pcR      <= pcNext;
        spR      <= spNext;
        extraCyc <= extraCyc + CYC_W'(needWord);
        if (strobe.selB) begin bKind <= kind; bSel <= sel; bVal <= val; end
        else begin aKind <= kind; aSel <= sel; aVal <= val; end
      end
    end
  end
endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
  import operand_resolver_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] spIn,
  output logic [2:0]        regRdIdx,
  input  logic [DATA_W-1:0] regRdData,
  output logic              fetchValid,
  output logic [DATA_W-1:0] fetchAddr,
  input  logic              fetchReady,
  input  logic [DATA_W-1:0] fetchData,
  output logic [1:0]        aKind,
  output logic [3:0]        aSel,
  output logic [DATA_W-1:0] aVal,
  output logic [1:0]        bKind,
  output logic [3:0]        bSel,
  output logic [DATA_W-1:0] bVal,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [1:0]        extraCyc,
  output logic              busy,
  output logic              done
);
  ctrlStrobe_t strobe;
  logic        needWord;

  opd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .needWord(needWord),
    .fetchReady(fetchReady), .strobe(strobe), .fetchValid(fetchValid), .busy(busy)
  );

  opd_path #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instr(instr), .pcIn(pcIn), .spIn(spIn),
    .regRdIdx(regRdIdx), .regRdData(regRdData), .fetchData(fetchData),
    .fetchAddr(fetchAddr), .needWord(needWord),
    .aKind(aKind), .aSel(aSel), .aVal(aVal), .bKind(bKind), .bSel(bSel), .bVal(bVal),
    .pcOut(pcOut), .spOut(spOut), .extraCyc(extraCyc), .done(done)
  );
endmodule

// File: rtl/operand_resolver_checker.sv
module operand_resolver_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [DATA_W-1:0] pcIn,
  input logic              fetchValid,
  input logic              fetchReady,
  input logic [DATA_W-1:0] fetchAddr,
  input logic [DATA_W-1:0] pcOut,
  input logic [1:0]        extraCyc,
  input logic              busy,
  input logic              done
);
  logic [DATA_W-1:0] pcCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcCap <= '0;
    else if (start && !busy) pcCap <= pcIn;
  end

  assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !fetchReady |=> fetchValid && $stable(fetchAddr));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_fetch_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> busy);

  assert_pc_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> pcOut == pcCap + DATA_W'(extraCyc));

  assert_extra_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> extraCyc <= 2'd2);

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
endmodule

bind operand_resolver operand_resolver_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rstN(rstN), .start(start), .pcIn(pcIn), .fetchValid(fetchValid),
  .fetchReady(fetchReady), .fetchAddr(fetchAddr), .pcOut(pcOut), .extraCyc(extraCyc),
  .busy(busy), .done(done)
);

// File: tb/operand_resolver_bench.sv
module operand_resolver_bench;
  logic clk = 0, rstN = 0, start = 0, fetchReady = 0;
  logic [15:0] instr = 0, pcIn = 0, spIn = 0;
  logic [2:0] regRdIdx;
  logic [15:0] regRdData, fetchAddr, fetchData, aVal, bVal, pcOut, spOut;
  logic fetchValid, busy, done;
  logic [1:0] aKind, bKind, extraCyc;
  logic [3:0] aSel, bSel;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] regVal(input int i);
    return 16'h1000 + 16'(i) * 16'h0111;
  endfunction
  function automatic logic [15:0] memWord(input logic [15:0] a);
    return a ^ 16'h5A5A;
  endfunction

  assign regRdData = regVal(int'(regRdIdx));
  assign fetchData = memWord(fetchAddr);

  operand_resolver u_operand_resolver (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  logic [15:0] fq[$];

  // behavioural model of one operand
  task automatic model(input int f, input bit isB, input bit ext, inout logic [15:0] p,
                       inout logic [15:0] s, inout int ex,
                       output int k, output int sl, output logic [15:0] v);
    logic [15:0] w;
    k = 0; sl = 0; v = 0;
    w = memWord(p);
    if (ext) begin k = 3; v = 16'(f); end
    else if (f >= 32) begin k = 2; v = 16'(f - 33); end
    else if (f < 8) sl = f;
    else if (f < 16) begin k = 1; v = regVal(f - 8); end
    else if (f < 24) begin k = 1; v = w + regVal(f - 16); fq.push_back(p); p++; ex++; end
    else if (f == 24 && isB) begin k = 1; s--; v = s; end
    else if (f == 24) begin k = 1; v = s; s++; end
    else if (f == 25) begin k = 1; v = s; end
    else if (f == 26) begin k = 1; v = s + w; fq.push_back(p); p++; ex++; end
    else if (f == 27) sl = 8;
    else if (f == 28) sl = 9;
    else if (f == 29) sl = 10;
    else if (f == 30) begin k = 1; v = w; fq.push_back(p); p++; ex++; end
    else begin k = 2; v = w; fq.push_back(p); p++; ex++; end
  endtask

  task automatic runOp(input string tag, input int op, input int bf, input int af,
                       input logic [15:0] pc, input logic [15:0] sp, input int stall, input bit poke);
    logic [15:0] p, s, av, bv;
    int ex, ak, as, bk, bs, lat, wc, nf;
    bit seen;
    p = pc; s = sp; ex = 0; fq.delete();
    model(af, 0, 0, p, s, ex, ak, as, av);
    model(bf, 1, op == 0, p, s, ex, bk, bs, bv);
    nf = fq.size();
    @(negedge clk);
    instr = 16'((af << 10) | (bf << 5) | op); pcIn = pc; spIn = sp; start = 1;
    lat = 0; wc = 0; seen = 0;
    for (int c = 1; c < 40 && !seen; c++) begin
      @(negedge clk);
      if (c == 1 && poke) begin instr = 16'hFFFF; pcIn = 16'h0; spIn = 16'h0; end
      else start = 0;
      if (fetchValid) begin
        if (fq.size() == 0) check(tag, 32'(fetchAddr), 32'hFFFFFFFF, "unexpected fetch");
        else check(tag, 32'(fetchAddr), 32'(fq[0]), "fetch address");
        if (wc < stall) begin fetchReady = 0; wc++; end
        else begin fetchReady = 1; wc = 0; if (fq.size() > 0) void'(fq.pop_front()); end
      end else fetchReady = 0;
      if (done) begin seen = 1; lat = c; end
    end
    start = 0; fetchReady = 0;
    check(tag, 32'(lat), 32'(3 + stall * nf), "done latency (R10)");
    check(tag, 32'(aKind), 32'(ak), "aKind");
    check(tag, 32'(aSel), 32'(as), "aSel");
    check(tag, 32'(aVal), 32'(av), "aVal");
    check(tag, 32'(bKind), 32'(bk), "bKind");
    check(tag, 32'(bSel), 32'(bs), "bSel");
    check(tag, 32'(bVal), 32'(bv), "bVal");
    check(tag, 32'(pcOut), 32'(p), "pcOut");
    check(tag, 32'(spOut), 32'(s), "spOut");
    check(tag, 32'(extraCyc), 32'(ex), "extraCyc");
    @(negedge clk);
    check(tag, 32'(done), 32'd0, "done pulse width (R10)");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", 32'({done, busy, fetchValid}), 32'd0, "reset outputs");
    rstN = 1;
    runOp("R1", 1, 5'h1b, 6'h03, 16'h0200, 16'hFFF0, 0, 0);
    runOp("R1", 2, 5'h1d, 6'h1c, 16'h0200, 16'hFFF0, 0, 0);
    runOp("R2", 3, 5'h0f, 6'h0a, 16'h0300, 16'h8000, 0, 0);
    runOp("R3", 2, 5'h15, 6'h12, 16'h0400, 16'h8000, 2, 0);
    runOp("R4", 1, 5'h18, 6'h18, 16'h0500, 16'h0000, 0, 0);
    runOp("R4", 1, 5'h18, 6'h03, 16'h0500, 16'h0000, 1, 0);
    runOp("R5", 1, 5'h1a, 6'h19, 16'h0600, 16'h7000, 1, 0);
    runOp("R6", 1, 5'h1f, 6'h1e, 16'h0700, 16'h7000, 3, 0);
    runOp("R7", 1, 5'h1d, 6'h20, 16'h0800, 16'h7000, 0, 0);
    runOp("R7", 1, 5'h00, 6'h3f, 16'h0800, 16'h7000, 0, 0);
    runOp("R7", 1, 5'h00, 6'h21, 16'h0800, 16'h7000, 0, 0);
    runOp("R8", 1, 5'h19, 6'h18, 16'h0900, 16'hFFFF, 0, 0);
    runOp("R8", 1, 5'h1e, 6'h1f, 16'hFFFF, 16'h1234, 1, 0);
    runOp("R9", 0, 5'h1f, 6'h1f, 16'h0A00, 16'h1234, 1, 0);
    runOp("R9", 0, 5'h18, 6'h05, 16'h0A00, 16'h1234, 0, 0);
    runOp("R11", 1, 5'h12, 6'h1a, 16'h0B00, 16'h2000, 0, 1);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      runOp("R8", int'(r[4:0]), int'(r[9:5]), int'(r[15:10]), r[31:16], 16'(r[15:0] ^ 16'hA5C3),
            int'(r[17:16]), r[20]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule